// File: doc/BRIEF.md
# Selectable Even Clock Divider

The divider takes one source clock and produces a slower clock whose period is an even multiple of the source period, from 2 up to 16 source cycles. A three-bit ratio code picks the ratio. Every high phase and every low phase of the divided clock lasts exactly half the chosen period, so the output always has a 50% duty cycle.

Ratio changes take effect only at a period boundary. The period already under way always completes at the old ratio, and the new code is taken when the next high phase starts. A synchronous reset forces the output low and clears the phase counter. When the enable input drops, the divider finishes its current period and then parks low. When it returns, the divider starts again with a full-length high phase. A status output reports the ratio code currently in effect. The divided clock is a registered output, so its phases can be counted in source-clock cycles.

Top module: `even_clk_divider`

## Requirements
- R1: Ratio code N on `ratio_sel` (binary, 0 to 7) selects a division ratio of 2*(N+1): code 0 gives 2 and code 7 gives 16.
- R2: Each high phase of `clk_div` lasts exactly N+1 source cycles, where N is the code shown on `ratio_active` during that phase.
- R3: While `enable` stays high, each low phase between two high phases lasts exactly N+1 source cycles, so the period is 2*(N+1).
- R4: `ratio_sel` is sampled only on the edge that starts a high phase, and during reset. A change in mid-period does not alter the current period. `ratio_active` holds the sampled code and changes only on those edges.
- R5: One edge after `rst` is sampled high, `clk_div` is low, and it stays low for as long as `rst` stays high. During reset `ratio_active` follows `ratio_sel`.
- R6: If `enable` is high on the first edge at which `rst` is low, `clk_div` rises on that edge, and this first high phase is a full N+1 cycles long.
- R7: If `enable` drops, the divider completes the current high phase and its full low phase, then holds `clk_div` low. When `enable` returns high during the park, `clk_div` rises on the next edge and gives a full-length high phase.
- R8: Outside reset, no low phase that follows a high phase is shorter than N+1 cycles, where N is the code of the period that is ending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run request; when low, the output parks low at a period boundary |
| ratio_sel | input | SEL_W | Ratio code N, ratio = 2*(N+1) |
| clk_div | output | 1 | Divided clock, registered, 50% duty |
| ratio_active | output | SEL_W | Ratio code currently in effect |

## Verification
The bench builds the divider with its default code width of three bits. At that width every legal ratio from 2 to 16 can be reached, and each ratio is swept by phase measurement in source cycles. Because the half-period counter is so small, directed cases can cover a reset in mid-phase, a ratio change in mid-period and an enable drop during both the high and the low phase, each within a few dozen cycles.

// File: rtl/ediv_pkg.sv
package ediv_pkg;

    localparam int DEF_SEL_W = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   load_code;
    } step_t;

    // Half-period length in source cycles for a given ratio code.
    function automatic int unsigned half_len(input int unsigned code);
        return code + 1;
    endfunction

endpackage

// File: rtl/ediv_half_counter.sv
module ediv_half_counter #(
    parameter int W = ediv_pkg::DEF_SEL_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         tc
);
    logic [W-1:0] cnt_q;

    assign tc = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (tc) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ediv_sequencer.sv
module ediv_sequencer #(
    parameter int W = ediv_pkg::DEF_SEL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic [W-1:0] sel_in,
    input  logic         tc,
    output logic         cnt_clr,
    output logic         clk_q,
    output logic [W-1:0] sel_q
);
    import ediv_pkg::*;

    phase_e phase_q;
    step_t  step;

    always_comb begin
        step.phase     = phase_q;
        step.load_code = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (enable) begin
                    step.phase     = PH_HIGH;
                    step.load_code = 1'b1;
                end
            end
            PH_HIGH: begin
                if (tc) step.phase = PH_LOW;
            end
            PH_LOW: begin
                if (tc) begin
                    if (enable) begin
                        step.phase     = PH_HIGH;
                        step.load_code = 1'b1;
                    end else begin
                        step.phase = PH_IDLE;
                    end
                end
            end
            default: step.phase = PH_IDLE;
        endcase
    end

    // The counter stays at zero while parked so a restart gives a full phase.
    assign cnt_clr = rst || (phase_q == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            clk_q   <= 1'b0;
            sel_q   <= sel_in;
        end else begin
            phase_q <= step.phase;
            clk_q   <= (step.phase == PH_HIGH);
            if (step.load_code) sel_q <= sel_in;
        end
    end
endmodule

// File: rtl/even_clk_divider.sv
module even_clk_divider #(
    parameter int SEL_W = ediv_pkg::DEF_SEL_W
) (
    input  logic             clk_src,
    input  logic             rst,
    input  logic             enable,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             clk_div,
    output logic [SEL_W-1:0] ratio_active
);
    logic             tc;
    logic             cnt_clr;
    logic [SEL_W-1:0] code_q;

    ediv_sequencer #(.W(SEL_W)) u_seq (
        .clk     (clk_src),
        .rst     (rst),
        .enable  (enable),
        .sel_in  (ratio_sel),
        .tc      (tc),
        .cnt_clr (cnt_clr),
        .clk_q   (clk_div),
        .sel_q   (code_q)
    );

    ediv_half_counter #(.W(SEL_W)) u_cnt (
        .clk   (clk_src),
        .clr   (cnt_clr),
        .limit (code_q),
        .tc    (tc)
    );

    assign ratio_active = code_q;
endmodule

// File: rtl/ediv_checker.sv
module ediv_checker #(
    parameter int SEL_W = ediv_pkg::DEF_SEL_W
) (
    input logic             clk_src,
    input logic             rst,
    input logic             clk_div,
    input logic [SEL_W-1:0] ratio_active
);
    logic       prev_rst = 1'b1;
    logic       prev_clk = 1'b0;
    logic       lo_from_high = 1'b0;
    logic [7:0] hi_len = '0;
    logic [7:0] lo_len = '0;

    always_ff @(posedge clk_src) begin
        prev_rst <= rst;
        prev_clk <= clk_div;
        if (rst) begin
            hi_len       <= '0;
            lo_len       <= '0;
            lo_from_high <= 1'b0;
        end else begin
            if (clk_div) hi_len <= (hi_len == 8'hFF) ? hi_len : hi_len + 1'b1;
            else         hi_len <= '0;
            if (!clk_div) lo_len <= (lo_len == 8'hFF) ? lo_len : lo_len + 1'b1;
            else          lo_len <= '0;
            if (prev_clk && !clk_div && !prev_rst) lo_from_high <= 1'b1;
            else if (clk_div)                      lo_from_high <= 1'b0;
        end
    end

    // R5: reset drives the divided clock low one edge later
    a_r5_reset_low: assert property (@(posedge clk_src)
        rst |=> !clk_div);

    // R2: a high phase that ends outside reset lasts exactly N+1 cycles
    a_r2_high_len: assert property (@(posedge clk_src) disable iff (rst)
        (!prev_rst && $fell(clk_div)) |->
            (int'(hi_len) == int'(ediv_pkg::half_len(int'(ratio_active)))));

    // R8: low phase after a high phase is never a runt
    a_r8_low_no_runt: assert property (@(posedge clk_src) disable iff (rst)
        (!prev_rst && lo_from_high && $rose(clk_div)) |->
            (int'(lo_len) >= int'(ediv_pkg::half_len(int'($past(ratio_active))))));

    // R4: active code changes only where a high phase starts
    a_r4_code_hold: assert property (@(posedge clk_src) disable iff (rst)
        (!prev_rst && !$rose(clk_div)) |-> $stable(ratio_active));
endmodule

bind even_clk_divider ediv_checker #(.SEL_W(SEL_W)) u_chk (
    .clk_src      (clk_src),
    .rst          (rst),
    .clk_div      (clk_div),
    .ratio_active (ratio_active)
);

// File: tb/tb_even_clk_divider.sv
module tb_even_clk_divider;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [SW-1:0] ratio_sel = '0;
    logic          clk_div;
    logic [SW-1:0] ratio_active;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    even_clk_divider #(.SEL_W(SW)) dut (
        .clk_src      (clk),
        .rst          (rst),
        .enable       (enable),
        .ratio_sel    (ratio_sel),
        .clk_div      (clk_div),
        .ratio_active (ratio_active)
    );

    localparam logic [SW-1:0] VEC_SEL [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam int            VEC_DIV [8] = '{2, 4, 6, 8, 10, 12, 14, 16};

    task automatic check(input int actual, input int expected, input string req);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Called at a negedge; waits for level lvl, returns its length at the negedge it ends.
    task automatic measure(input logic lvl, output int len);
        int guard = 0;
        while (clk_div !== lvl && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        len = 0;
        while (clk_div === lvl && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input logic [SW-1:0] code);
        @(negedge clk);
        rst = 1'b1;
        enable = 1'b1;
        ratio_sel = code;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int len;
        int cnt;
        // R5: reset state
        repeat (3) @(negedge clk);
        check(int'(clk_div), 0, "R5 reset output");
        check(int'(ratio_active), 0, "R5 reset code follows select");

        // R1 R2 R3: sweep of all ratio codes
        for (int i = 0; i < 8; i++) begin
            restart(VEC_SEL[i]);
            check(int'(ratio_active), int'(VEC_SEL[i]), "R1 active code");
            measure(1'b1, len);
            check(len, VEC_DIV[i] / 2, "R2 high phase");
            measure(1'b0, len);
            check(len, VEC_DIV[i] / 2, "R3 low phase");
            measure(1'b1, len);
            check(len, VEC_DIV[i] / 2, "R2 second high phase");
            measure(1'b0, len);
            check(len, VEC_DIV[i] / 2, "R3 second low phase");
        end

        // R6: first edge after reset release rises, full high phase
        @(negedge clk);
        rst = 1'b1; ratio_sel = 3'd4; enable = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(int'(clk_div), 1, "R6 rise on first edge");
        len = 0;
        while (clk_div === 1'b1 && len < 100) begin len++; @(negedge clk); end
        check(len, 5, "R6 first high full length");

        // R5: reset in mid-high phase
        measure(1'b0, len);
        @(negedge clk);
        check(int'(clk_div), 1, "R5 running before reset");
        rst = 1'b1; ratio_sel = 3'd2;
        @(negedge clk);
        check(int'(clk_div), 0, "R5 low one edge after reset");
        cnt = 0;
        repeat (4) begin @(negedge clk); if (clk_div !== 1'b0) cnt++; end
        check(cnt, 0, "R5 held low during reset");
        check(int'(ratio_active), 2, "R5 code follows select in reset");
        rst = 1'b0;
        @(negedge clk);
        len = 0;
        while (clk_div === 1'b1 && len < 100) begin len++; @(negedge clk); end
        check(len, 3, "R6 high after mid-phase reset");

        // R4: ratio change in mid-high phase
        restart(3'd1);
        len = 1;
        ratio_sel = 3'd6;
        @(negedge clk);
        while (clk_div === 1'b1 && len < 100) begin len++; @(negedge clk); end
        check(len, 2, "R4 current high keeps old ratio");
        check(int'(ratio_active), 1, "R4 code held in low phase");
        measure(1'b0, len);
        check(len, 2, "R4 current low keeps old ratio");
        check(int'(ratio_active), 6, "R4 new code at period start");
        measure(1'b1, len);
        check(len, 7, "R4 new high length");

        // R7: enable dropped during high phase
        restart(3'd2);
        enable = 1'b0;
        len = 1;
        @(negedge clk);
        while (clk_div === 1'b1 && len < 100) begin len++; @(negedge clk); end
        check(len, 3, "R7 high completes after disable");
        cnt = 0;
        repeat (20) begin if (clk_div !== 1'b0) cnt++; @(negedge clk); end
        check(cnt, 0, "R7 parked low");
        enable = 1'b1;
        @(negedge clk);
        check(int'(clk_div), 1, "R7 restart on next edge");
        len = 0;
        while (clk_div === 1'b1 && len < 100) begin len++; @(negedge clk); end
        check(len, 3, "R7 full high after restart");

        // R7 R8: enable dropped during low phase, low not cut short
        measure(1'b0, len);
        check(len, 3, "R8 low phase full");
        measure(1'b1, len);
        @(negedge clk);
        enable = 1'b0;
        cnt = 1;
        while (clk_div === 1'b0 && cnt < 30) begin cnt++; @(negedge clk); end
        check(cnt, 30, "R7 stays parked after low-phase disable");
        enable = 1'b1;
        @(negedge clk);
        measure(1'b1, len);
        check(len, 3, "R7 high after resume");
        measure(1'b0, len);
        check(len, 3, "R8 low after resume");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule